// File: doc/BRIEF.md
# Prioritized Interrupt and Wakeup Controller

This block gathers interrupt requests and decides which one the processor should serve. Six single-cycle request pulses come from the timers, the two time bases and the real-time clock. An external pin adds a request, and a key-change detector watching an input port adds another. Each request sets a sticky status flag. An enable mask decides which flags raise the maskable interrupt line. A fixed priority encoder reports the winning source as a 3-bit index. The first timer's flag can be steered to a separate non-maskable line, and that line does not consult the mask.

The same block also manages low-power sleep. Software arms one or more wake sources and writes a command byte to the sleep register. The key value puts the block to sleep; any other value produces a reset request. A wake source that fires while asleep raises a one-cycle wake pulse and ends sleep. The key and pin inputs pass through a shared de-glitch filter, so short noise pulses neither set flags nor wake the system.

Top module: `irq_wake_ctrl`

## Requirements
- R1: Source bit positions, from highest to lowest priority, are 0 first timer, 1 second timer, 2 third timer, 3 first time base, 4 second time base, 5 real-time clock, 6 key change, 7 external pin. `vec` gives the lowest-numbered bit that is both flagged and enabled.
- R2: `irq` is high exactly when some status flag (address 1) and its enable bit (address 0) are both set. Clearing the winning flag moves `vec` on to the next pending source.
- R3: A request sets its status flag whatever its enable bit is. Removing the enable drops `irq`, but the flag stays readable.
- R4: When control bit 1 (address 2) is set, the bit-0 flag drives `nmi` regardless of the mask and no longer takes part in `irq`. When control bit 1 is clear, `nmi` stays low.
- R5: Writing to the status register clears each flag whose written bit is 1 and leaves the other flags unchanged.
- R6: Control bit 0 selects the external pin edge that sets flag 7: 1 for a low-to-high edge, 0 for a high-to-low edge. The other edge sets nothing.
- R7: Reading the key register (address 3) returns the live port and stores it as a snapshot. When the port then differs from the snapshot, flag 6 is set once. A port equal to the snapshot sets nothing.
- R8: A key-change flag raises `irq` only while enable bit 6 is set.
- R9: Control bits [3:2] select the de-glitch width. Code 00 filters nothing. Codes 01, 10 and 11 require a key mismatch or a pin change to persist for at least 4, 16 and 64 clocks before it counts. Shorter pulses are ignored.
- R10: Writing 0x5A to the sleep register (address 4) sets `sleep_o` when at least one wake enable is set. The wake enables are control bit 4 (key), bit 5 (pin) and bit 6 (real-time clock).
- R11: A 0x5A write with no wake enable set leaves `sleep_o` low and raises no reset request.
- R12: Writing any value other than 0x5A to the sleep register pulses `reset_req` for exactly one cycle after the write.
- R13: While asleep, an enabled wake event raises `wake_o` in the same cycle, and `sleep_o` falls at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| src_req | input | 6 | Request pulses for sources 0 to 5 |
| ext_pin | input | 1 | External interrupt pin |
| key_port | input | KEY_W | Watched key port |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |
| vec | output | 3 | Winning source index |
| sleep_o | output | 1 | Sleep state |
| wake_o | output | 1 | Wake pulse |
| reset_req | output | 1 | Reset request pulse |

## Verification
The priority encoder is driven with several requests arriving together, under a full mask and under a partial mask. This separates ordering errors from masking errors, and stepwise clearing shows the handover to the next pending source. The pin is toggled in both directions under each edge setting, so a swapped polarity shows up. Key and pin pulses are applied both shorter and longer than the selected filter width, so a filter that is too loose or too strict is caught. Sleep writes are tried with the key value, with a wrong value, and with no wake source armed, and two different wake sources are used to end sleep.

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int KEY_W = 8,
  parameter int DG1 = 4,
  parameter int DG2 = 16,
  parameter int DG3 = 64,
  parameter logic [7:0] SLEEP_KEY = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [5:0]       src_req,
  input  logic             ext_pin,
  input  logic [KEY_W-1:0] key_port,
  output logic             irq,
  output logic             nmi,
  output logic [2:0]       vec,
  output logic             sleep_o,
  output logic             wake_o,
  output logic             reset_req
);
  localparam int CW = $clog2(DG3 + 2);
  localparam logic [2:0] A_EN = 3'd0, A_ST = 3'd1, A_CTL = 3'd2, A_KEY = 3'd3, A_SLP = 3'd4;

  logic [7:0]       en_q, st_q;
  logic [6:0]       ctl_q;
  logic [KEY_W-1:0] snap_q;
  logic [CW-1:0]    kcnt_q, ecnt_q, thr;
  logic             ext_f_q, sleep_q, rst_req_q;

  always_comb
    case (ctl_q[3:2])
      2'd0:    thr = '0;
      2'd1:    thr = CW'(DG1);
      2'd2:    thr = CW'(DG2);
      default: thr = CW'(DG3);
    endcase

  wire key_diff = key_port != snap_q;
  wire key_ev   = key_diff && (kcnt_q == thr);
  wire ext_chg  = ext_pin != ext_f_q;
  wire ext_upd  = ext_chg && (ecnt_q >= thr);
  wire ext_ev   = ext_upd && (ext_pin == ctl_q[0]);

  wire [7:0] set_v = {ext_ev, key_ev, src_req};
  wire [7:0] clr_v = (wr_en && addr == A_ST) ? wdata : 8'h00;
  wire [7:0] pend  = st_q & en_q & {7'h7F, ~ctl_q[1]};

  wire slp_wr   = wr_en && addr == A_SLP;
  wire wake_arm = |ctl_q[6:4];
  wire wake_hit = (ctl_q[4] & key_ev) | (ctl_q[5] & ext_ev) | (ctl_q[6] & src_req[5]);

  assign irq       = |pend;
  assign nmi       = ctl_q[1] & st_q[0];
  assign wake_o    = sleep_q & wake_hit;
  assign sleep_o   = sleep_q;
  assign reset_req = rst_req_q;

  always_comb begin
    vec = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (pend[i]) vec = 3'(i);
  end

  always_comb
    case (addr)
      A_EN:    rdata = en_q;
      A_ST:    rdata = st_q;
      A_CTL:   rdata = {1'b0, ctl_q};
      A_KEY:   rdata = 8'(key_port);
      A_SLP:   rdata = {7'd0, sleep_q};
      default: rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q      <= '0;
      st_q      <= '0;
      ctl_q     <= '0;
      snap_q    <= '0;
      kcnt_q    <= '0;
      ecnt_q    <= '0;
      ext_f_q   <= 1'b0;
      sleep_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      st_q <= (st_q & ~clr_v) | set_v;
      if (wr_en && addr == A_EN)  en_q  <= wdata;
      if (wr_en && addr == A_CTL) ctl_q <= wdata[6:0];
      if (rd_en && addr == A_KEY) snap_q <= key_port;

      if (!key_diff)         kcnt_q <= '0;
      else if (kcnt_q <= thr) kcnt_q <= kcnt_q + 1'b1;

      if (!ext_chg || ext_upd) ecnt_q <= '0;
      else                     ecnt_q <= ecnt_q + 1'b1;
      if (ext_upd) ext_f_q <= ext_pin;

      if (wake_o)                                    sleep_q <= 1'b0;
      else if (slp_wr && wdata == SLEEP_KEY && wake_arm) sleep_q <= 1'b1;

      rst_req_q <= slp_wr && (wdata != SLEEP_KEY);
    end
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk #(
  parameter logic [7:0] SLEEP_KEY = 8'h5A
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       nmi,
  input logic [2:0] vec,
  input logic       sleep_o,
  input logic       wake_o,
  input logic       reset_req
);
  // R13
  wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n) wake_o |-> sleep_o);
  // R13
  wake_ends_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n) wake_o |=> !sleep_o);
  // R10
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(wr_en && addr == 3'd4 && wdata == SLEEP_KEY));
  // R12
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_en && addr == 3'd4 && wdata != SLEEP_KEY));
  // R4
  nmi_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> !(irq && vec == 3'd0));
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(.SLEEP_KEY(SLEEP_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .nmi(nmi), .vec(vec), .sleep_o(sleep_o), .wake_o(wake_o),
  .reset_req(reset_req)
);

// File: tb/sim_irq_wake_ctrl.sv
`timescale 1ns/1ps
module sim_irq_wake_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [5:0] src_req = 6'd0;
  logic       ext_pin = 1'b0;
  logic [7:0] key_port = 8'h00;
  logic       irq, nmi, sleep_o, wake_o, reset_req;
  logic [2:0] vec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_wake_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_req(src_req), .ext_pin(ext_pin), .key_port(key_port),
    .irq(irq), .nmi(nmi), .vec(vec), .sleep_o(sleep_o), .wake_o(wake_o), .reset_req(reset_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    cyc(1);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m);
    src_req = m;
    cyc(1);
    src_req = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R2 reset irq", irq, 0);
    chk("R4 reset nmi", nmi, 0);
    chk("R10 reset sleep", sleep_o, 0);
    chk("R12 reset req", reset_req, 0);
    rd(3'd1, d);
    chk("R5 reset status", d, 8'h00);
  endtask

  task automatic t_priority;
    wr(3'd0, 8'hFF);
    pulse(6'b010100);
    chk("R2 irq up", irq, 1);
    chk("R1 vec third timer", vec, 2);
    wr(3'd1, 8'h04);
    chk("R2 next vec", vec, 4);
    wr(3'd1, 8'h10);
    chk("R2 irq cleared", irq, 0);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(3'd0, 8'h10);
    pulse(6'b000101);
    pulse(6'b010000);
    chk("R1 masked vec", vec, 4);
    wr(3'd0, 8'h00);
    chk("R3 mask drops irq", irq, 0);
    rd(3'd1, d);
    chk("R3 flags kept", d, 8'h15);
    wr(3'd1, 8'h04);
    rd(3'd1, d);
    chk("R5 partial clear", d, 8'h11);
    wr(3'd1, 8'hFF);
  endtask

  task automatic t_nmi;
    wr(3'd2, 8'h02);
    wr(3'd0, 8'h01);
    pulse(6'b000001);
    chk("R4 nmi up", nmi, 1);
    chk("R4 no irq", irq, 0);
    wr(3'd1, 8'h01);
    chk("R5 nmi cleared", nmi, 0);
    wr(3'd2, 8'h00);
    pulse(6'b000001);
    chk("R4 unrouted nmi", nmi, 0);
    chk("R4 unrouted irq", irq, 1);
    wr(3'd1, 8'hFF);
  endtask

  task automatic t_ext;
    wr(3'd0, 8'h80);
    wr(3'd2, 8'h00);
    ext_pin = 1'b1; cyc(2);
    chk("R6 rise ignored", irq, 0);
    ext_pin = 1'b0; cyc(1);
    chk("R6 fall flagged", irq, 1);
    chk("R6 vec", vec, 7);
    wr(3'd1, 8'h80);
    wr(3'd2, 8'h01);
    ext_pin = 1'b1; cyc(1);
    chk("R6 rise flagged", irq, 1);
    wr(3'd1, 8'h80);
    ext_pin = 1'b0; cyc(2);
    chk("R6 fall ignored", irq, 0);
  endtask

  task automatic t_key;
    logic [7:0] d;
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    key_port = 8'h21; cyc(1);
    rd(3'd3, d);
    chk("R7 live read", d, 8'h21);
    key_port = 8'h20; cyc(1);
    rd(3'd1, d);
    chk("R7 mismatch flag", d, 8'h40);
    chk("R8 key disabled", irq, 0);
    wr(3'd0, 8'h40);
    chk("R8 key enabled", irq, 1);
    chk("R1 key vec", vec, 6);
    rd(3'd3, d);
    wr(3'd1, 8'h40);
    cyc(3);
    chk("R7 match no flag", irq, 0);
  endtask

  task automatic t_deglitch;
    logic [7:0] d;
    wr(3'd0, 8'hC0);
    wr(3'd2, 8'h04);
    key_port = 8'h24; cyc(2);
    key_port = 8'h20; cyc(3);
    chk("R9 short key", irq, 0);
    key_port = 8'h24; cyc(10);
    chk("R9 long key", irq, 1);
    rd(3'd3, d);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h0C);
    key_port = 8'h20; cyc(40);
    key_port = 8'h24; cyc(3);
    chk("R9 code3 short", irq, 0);
    key_port = 8'h20; cyc(100);
    chk("R9 code3 long", irq, 1);
    rd(3'd3, d);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h05);
    ext_pin = 1'b1; cyc(2);
    ext_pin = 1'b0; cyc(3);
    chk("R9 short pin", irq, 0);
    ext_pin = 1'b1; cyc(10);
    chk("R9 long pin", irq, 1);
    ext_pin = 1'b0; cyc(10);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_sleep;
    logic [7:0] d;
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h5A);
    chk("R11 no source", sleep_o, 0);
    chk("R11 no reset", reset_req, 0);
    wr(3'd4, 8'h33);
    chk("R12 reset pulse", reset_req, 1);
    cyc(1);
    chk("R12 pulse ends", reset_req, 0);
    wr(3'd2, 8'h10);
    rd(3'd3, d);
    wr(3'd4, 8'h5A);
    chk("R10 asleep", sleep_o, 1);
    chk("R10 no reset", reset_req, 0);
    key_port = 8'h01;
    #1 chk("R13 key wake pulse", wake_o, 1);
    cyc(1);
    chk("R13 awake", sleep_o, 0);
    wr(3'd2, 8'h40);
    wr(3'd4, 8'h5A);
    chk("R10 asleep rtc", sleep_o, 1);
    pulse(6'b100000);
    chk("R13 rtc wake", sleep_o, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_priority();
    t_mask();
    t_nmi();
    t_ext();
    t_key();
    t_deglitch();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule